// File: doc/BRIEF.md
# Extended-Range Multi-Modulus Clock Divider

This block divides a fast input clock by a programmable integer that may stay fixed or change on every divided period. The dynamic stage is a ripple chain of divide-by-2/3 cells, modelled cycle by cycle on the input clock. A chain of `n` running cells divides by `2^n` plus the program bits below the leading one, so the number of running cells follows the leading one of the requested ratio. The divide range can therefore span several powers of two rather than a single factor of two. Cells above the running length are held cleared, not left free-running. When the ratio crosses a power of two, the newly added cell starts from a known state and the first period comes out right.

A static group divider sits after the chain. It merges a programmable number of consecutive chain periods into one output period, so the overall ratio is the sum of those chain ratios. An external modulator watches the per-period strobe and supplies the next modulus word. The word is taken only at the last input cycle of a chain period, so no period ever mixes two ratios. Out-of-range words are clamped to the chain limits and flagged.

Top module: `mmd_ext_divider`

## Requirements
- R1: With a group size of 1 and a modulus word W held constant in the range 4 to 2^(NCELLS+1)-1 (127 by default), `chain_stb` pulses exactly once every W input clocks.
- R2: A ratio whose leading one is at bit position n runs the lowest n cells, each swallowing one extra input cycle when its ratio bit is 1, so the period is 2^n plus the lower n bits. Even and odd ratios at and between powers of two all give their exact value.
- R3: The modulus word is sampled only at the last input clock of a chain period and governs the whole next period. A change of the word in the middle of a period does not alter that period's length.
- R4: When the ratio steps across a power-of-two boundary in either direction (15 to 16, 16 to 15, 31 to 32, 127 to 4, 4 to 127), the first period at the new ratio already has the new length.
- R5: A word below 4 is clamped to 4 and a word above 2^(NCELLS+1)-1 is clamped to that maximum. `range_flag` is 1 throughout exactly those periods that use a clamped word, and 0 during periods that use an in-range word.
- R6: With group size G, `div_clk` has one rising edge per G consecutive chain periods, spaced by the sum of their ratios (G=3 with ratios 15, 10, 10 gives 35). A group size of 0 acts as 1. The group size is sampled at group boundaries.
- R7: `chain_stb` is high for exactly one input clock, in the first clock of each chain period. Every rising edge of `div_clk` falls in the same clock as a `chain_stb` pulse.
- R8: While `rst_n` is low, `div_clk`, `chain_stb` and `range_flag` are 0. The first period after reset uses the default ratio DEF_RATIO (16), so the first `chain_stb` appears 16 input clocks after release, whatever the modulus word is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| post_div | input | PDW | Number of chain periods merged into one `div_clk` period (0 acts as 1) |
| mod_word | input | NCELLS+2 | Ratio requested for the next chain period |
| div_clk | output | 1 | Divided output clock; rises at each group start |
| chain_stb | output | 1 | One-clock pulse at the start of every chain period |
| range_flag | output | 1 | Current chain period runs on a clamped ratio |

## Verification
The hardest condition to reach from the ports is a ratio change that grows or shrinks the running chain at the exact clock where the old period ends. A newly used cell is only correct then if it left its cleared state on that boundary. The stimulus reaches this condition by changing the modulus word on the clock that follows each strobe. This places a chosen sequence of boundary-crossing ratios (15, 16, 15, 31, 32, 63, 64, 127, 4, 127) on back-to-back periods. Each period length is then measured in input clocks between strobes. A word change placed in the middle of a long period, and a 15/10/10 pattern under a group size of 3, cover the sampling point and the group summation.

// File: rtl/mmd_pkg.sv
// Package: shared constants and helpers for the extended-range divider.
// Assumes ratios fit in 32 bits.
package mmd_pkg;

    // Smallest ratio the chain can produce (two running cells).
    localparam int MMD_MIN_RATIO = 4;

    // Position of the most significant set bit (0 when v is 0).
    function automatic int msb_pos(input int unsigned v);
        int r;
        r = 0;
        for (int b = 0; b < 32; b++) begin
            if (v[b]) r = b;
        end
        return r;
    endfunction

endpackage

// File: rtl/mmd_cell.sv
// Module: one divide-by-2/3 cell of the chain, expressed with clock enables.
// Counts enable pulses from the cell below. A period is two pulses, or
// three when the modulus input and the program bit are both high. Assumes
// mod_in is stable over the cell's period (it comes from the cell above).
module mmd_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,     // cell beyond the running length: kept cleared
    input  logic en_in,    // one pulse per period of the cell below
    input  logic mod_in,   // this period is the last one in the cycle
    input  logic prog,     // swallow bit
    output logic en_out,   // one pulse per own period
    output logic mod_out   // last sub-period of the cycle, to the cell below
);
    logic [1:0] cnt;
    logic       swallow;
    logic       last_sub;

    // Decide whether the current sub-period is the final one of this period.
    always_comb begin
        swallow  = mod_in & prog;
        last_sub = swallow ? (cnt == 2'd2) : (cnt == 2'd1);
    end

    // Advance the sub-period count, clearing while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) cnt <= 2'd0;
        else if (en_in)     cnt <= last_sub ? 2'd0 : cnt + 2'd1;
    end

    // Report period completion and the modulus window downward.
    always_comb begin
        en_out  = en_in & last_sub & ~hold;
        mod_out = mod_in & last_sub & ~hold;
    end

    // R2
    // a third sub-period may only occur while swallowing
    cnt_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mod_in && prog) |-> (cnt != 2'd2));

endmodule

// File: rtl/mmd_ratio_ctrl.sv
// Module: ratio register and chain-length decode.
// Samples the modulus word only at the chain's end-of-cycle clock, clamps
// it to the chain limits and decodes which cells run and which cell ends
// the chain. Assumes DEF_RATIO lies within the chain limits.
module mmd_ratio_ctrl #(
    parameter int NCELLS    = 6,
    parameter int MW        = NCELLS + 2,
    parameter int DEF_RATIO = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_end,
    input  logic [MW-1:0]     mod_word,
    output logic [NCELLS-1:0] prog,
    output logic [NCELLS-1:0] active,
    output logic [NCELLS-1:0] tail,
    output logic              range_flag
);
    import mmd_pkg::*;

    localparam int RW    = NCELLS + 1;
    localparam int MAX_R = (2 ** (NCELLS + 1)) - 1;

    logic [RW-1:0] ratio_q;
    logic [RW-1:0] clamped;
    logic          oor;
    int            len;

    // Clamp the incoming word to the producible range.
    always_comb begin
        oor = 1'b1;
        if (int'(mod_word) < MMD_MIN_RATIO)  clamped = RW'(MMD_MIN_RATIO);
        else if (int'(mod_word) > MAX_R)     clamped = RW'(MAX_R);
        else begin
            clamped = mod_word[RW-1:0];
            oor     = 1'b0;
        end
    end

    // Take a new ratio only at the end of a chain period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q    <= RW'(DEF_RATIO);
            range_flag <= 1'b0;
        end else if (cyc_end) begin
            ratio_q    <= clamped;
            range_flag <= oor;
        end
    end

    // Running length is the position of the leading one.
    always_comb len = msb_pos(32'(ratio_q));

    for (genvar i = 0; i < NCELLS; i++) begin : g_dec
        assign active[i] = (len > i);
        assign tail[i]   = (len == i + 1);
        assign prog[i]   = ratio_q[i];
    end

    // R3
    // ratio holds between period ends
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_end |=> $stable(ratio_q));

    // R5
    // low words clamp to the minimum and raise the flag
    clamp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && int'(mod_word) < MMD_MIN_RATIO)
        |=> (range_flag && int'(ratio_q) == MMD_MIN_RATIO));

    // R5
    // high words clamp to the maximum and raise the flag
    clamp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && int'(mod_word) > MAX_R)
        |=> (range_flag && int'(ratio_q) == MAX_R));

endmodule

// File: rtl/mmd_post.sv
// Module: static group divider and output shaping.
// Counts chain periods and raises div_clk at the start of every group of
// post_div periods. div_clk is cleared by the second cell's modulus window,
// which always occurs before a period ends. Assumes the chain ratio is at least 4.
module mmd_post #(
    parameter int PDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cyc_end,
    input  logic           sec_mod,
    input  logic [PDW-1:0] post_div,
    output logic           div_clk,
    output logic           chain_stb
);
    logic [PDW-1:0] pdiv_q;
    logic [PDW-1:0] pcnt;
    logic [PDW-1:0] pdiv_eff;
    logic           group_end;

    // Treat a zero group size as one and find the group's last period end.
    always_comb begin
        pdiv_eff  = (post_div == '0) ? PDW'(1) : post_div;
        group_end = cyc_end && (pcnt == pdiv_q - PDW'(1));
    end

    // Count chain periods inside a group; reload the size at group ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt   <= '0;
            pdiv_q <= PDW'(1);
        end else if (group_end) begin
            pcnt   <= '0;
            pdiv_q <= pdiv_eff;
        end else if (cyc_end) begin
            pcnt   <= pcnt + PDW'(1);
        end
    end

    // Shape the outputs: strobe per period, clock edge per group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_stb <= 1'b0;
            div_clk   <= 1'b0;
        end else begin
            chain_stb <= cyc_end;
            if (group_end)    div_clk <= 1'b1;
            else if (sec_mod) div_clk <= 1'b0;
        end
    end

    // R7
    // strobe lasts a single clock
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_stb |=> !chain_stb);

    // R7
    // output edges coincide with period starts
    rise_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_clk) |-> chain_stb);

endmodule

// File: rtl/mmd_ext_divider.sv
// Module: extended-range multi-modulus divider (top).
// Chain of NCELLS divide-by-2/3 cells whose running length follows the
// ratio's leading one. Unused cells are held cleared. A group divider
// follows. Assumes DEF_RATIO is within 4..2^(NCELLS+1)-1.
module mmd_ext_divider #(
    parameter int NCELLS    = 6,
    parameter int PDW       = 3,
    parameter int DEF_RATIO = 16,
    parameter int MW        = NCELLS + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PDW-1:0] post_div,
    input  logic [MW-1:0]  mod_word,
    output logic           div_clk,
    output logic           chain_stb,
    output logic           range_flag
);
    logic [NCELLS-1:0] prog;
    logic [NCELLS-1:0] active;
    logic [NCELLS-1:0] tail;
    logic [NCELLS:0]   en_up;
    logic [NCELLS:0]   mod_dn;
    logic [NCELLS-1:0] mod_in;
    logic              cyc_end;

    mmd_ratio_ctrl #(
        .NCELLS(NCELLS), .MW(MW), .DEF_RATIO(DEF_RATIO)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .mod_word(mod_word),
        .prog(prog), .active(active), .tail(tail), .range_flag(range_flag)
    );

    // Bottom cell sees every input clock; nothing above the top cell.
    assign en_up[0]       = 1'b1;
    assign mod_dn[NCELLS] = 1'b0;

    for (genvar i = 0; i < NCELLS; i++) begin : g_cell
        // The last running cell gets its modulus input forced high.
        assign mod_in[i] = tail[i] | mod_dn[i+1];
        mmd_cell u_cell (
            .clk(clk), .rst_n(rst_n), .hold(~active[i]),
            .en_in(en_up[i]), .mod_in(mod_in[i]), .prog(prog[i]),
            .en_out(en_up[i+1]), .mod_out(mod_dn[i])
        );
    end

    assign cyc_end = mod_dn[0];

    mmd_post #(.PDW(PDW)) u_post (
        .clk(clk), .rst_n(rst_n), .cyc_end(cyc_end), .sec_mod(mod_dn[1]),
        .post_div(post_div), .div_clk(div_clk), .chain_stb(chain_stb)
    );

    // R4
    // every running cell completes its period on the chain's last clock
    wrap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_end |-> &(en_up[NCELLS:1] | ~active));

endmodule

// File: tb/sim_mmd_ext_divider.sv
// Bench: table-driven period checks followed by directed reset and corner tests.
module sim_mmd_ext_divider;
    localparam int MAXR = 127;
    localparam int NV   = 16;
    localparam int WORDS[NV] = '{15, 16, 15, 31, 32, 63, 64, 127, 4, 5, 127, 2, 200, 9, 0, 7};
    localparam int EXPS [NV] = '{15, 16, 15, 31, 32, 63, 64, 127, 4, 5, 127, 4, 127, 9, 4, 7};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] post_div = 3'd1;
    logic [7:0] mod_word = 8'd9;
    logic       div_clk, chain_stb, range_flag;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    mmd_ext_divider u0 (
        .clk(clk), .rst_n(rst_n), .post_div(post_div), .mod_word(mod_word),
        .div_clk(div_clk), .chain_stb(chain_stb), .range_flag(range_flag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count negedges until the next strobe is seen.
    task automatic wait_stb(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!chain_stb);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n, acc, grp;
        // R8: reset state and default first period
        repeat (3) @(negedge clk);
        chk(div_clk == 1'b0, "R8 div_clk in reset", int'(div_clk), 0);
        chk(chain_stb == 1'b0, "R8 chain_stb in reset", int'(chain_stb), 0);
        chk(range_flag == 1'b0, "R8 range_flag in reset", int'(range_flag), 0);
        rst_n = 1'b1;
        wait_stb(n);
        chk(n == 16, "R8 first period uses default", n, 16);
        wait_stb(n);
        chk(n == 9, "R1 held word 9", n, 9);

        // R1 R2 R4 R5: table walk, word set on the clock after each strobe
        mod_word = 8'(WORDS[0]);
        wait_stb(n);
        mod_word = 8'(WORDS[1]);
        for (int k = 0; k < NV; k++) begin
            bit fexp;
            wait_stb(n);
            mod_word = (k + 2 < NV) ? 8'(WORDS[k+2]) : 8'(WORDS[NV-1]);
            chk(n == EXPS[k], "R2/R4 period vs table", n, EXPS[k]);
            if (k + 1 < NV) begin
                fexp = (WORDS[k+1] < 4) || (WORDS[k+1] > MAXR);
                chk(range_flag == fexp, "R5 range_flag", int'(range_flag), int'(fexp));
            end
        end

        // R7: strobe width
        @(negedge clk);
        chk(chain_stb == 1'b0, "R7 strobe one clock", int'(chain_stb), 0);

        // R3: mid-period word change does not shorten the running period
        wait_stb(n);
        mod_word = 8'd40;
        wait_stb(n);
        n = 0;
        repeat (10) begin
            @(negedge clk);
            n++;
        end
        mod_word = 8'd6;
        do begin
            @(negedge clk);
            n++;
        end while (!chain_stb);
        chk(n == 40, "R3 mid-period change ignored", n, 40);
        wait_stb(n);
        chk(n == 6, "R3 new word next period", n, 6);

        // R6 R7: group of 3 with pattern 15,10,10
        post_div = 3'd3;
        acc = 0;
        grp = 0;
        for (int k = 0; k < 21; k++) begin
            wait_stb(n);
            mod_word = (k % 3 == 0) ? 8'd15 : 8'd10;
            acc += n;
            if (div_clk) begin
                if (grp >= 2) chk(acc == 35, "R6 group sum 35", acc, 35);
                grp++;
                acc = 0;
            end
        end
        chk(grp >= 5, "R6 group edges seen", grp, 5);

        // R6: group size 0 acts as 1
        post_div = 3'd0;
        mod_word = 8'd8;
        for (int k = 0; k < 10; k++) begin
            wait_stb(n);
            if (k >= 5) begin
                chk(n == 8, "R6 size0 period", n, 8);
                chk(div_clk == 1'b1, "R7 div_clk rises with strobe", int'(div_clk), 1);
            end
        end
        finish_run();
    end
endmodule